// File: doc/BRIEF.md
# Prescaled Output-Compare PWM Generator

This block produces one pulse-width-modulated output from a programmable timebase. A prescaler divides the clock by a selectable power-of-two ratio. Each prescaled tick advances an up-counting timer. The timer runs from zero up to a programmed period value and then wraps. The output is high from the start of each period until the timer reaches a programmed compare value. A one-clock strobe marks every wrap.

Software programs the period, the compare value, the prescale ratio and an enable bit through a simple synchronous write port. Period and compare writes go to holding registers. These holding values reach the working registers only at a wrap, or at any time while the block is disabled. A running waveform therefore never shows a period built from a mix of old and new settings.

Top module: `pwm_oc_gen`

## Requirements
- R1: The timer advances by one on each prescaled tick. The 3-bit prescale select in the control word picks the ratio of clocks per tick: codes 0 to 6 give 1, 2, 4, 8, 16, 32 and 64, and code 7 gives 256.
- R2: The timer counts from 0 up to the working period value P and returns to 0 on the tick after it equals P, so one period lasts P+1 ticks. `wrap_o` is high for exactly one clock per wrap, in the first clock in which the timer reads 0.
- R3: With working compare C and 0 < C < P, the output is high for the first C ticks of each period (timer values 0 to C-1) and low for the rest, which gives a duty of C/(P+1).
- R4: With the default 8-bit width, P = 255 gives 256 ticks per period, and each compare step changes the high time by one tick (8-bit resolution).
- R5: A nonzero compare value with C >= P keeps the output high for the whole period.
- R6: A compare value of 0 keeps the output low for the whole period, whatever the period value.
- R7: Writes to address 0 (period) and address 1 (compare) take effect only at the next wrap. The period that is running when a write arrives completes with the old value.
- R8: Address 2 is the control word: bit 0 is enable and bits 3:1 are the prescale select. While enable is low, the timer and prescaler are held at 0, `pwm_o` is low and `wrap_o` never pulses.
- R9: A write that changes the prescale select restarts the prescaler count. The first tick after such a write therefore arrives a full new ratio of clocks later.
- R10: After reset the block is disabled, `pwm_o` and `wrap_o` are low, and the period, compare and select registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 period, 1 compare, 2 control |
| wr_data_i | input | CNT_W | Write data |
| pwm_o | output | 1 | PWM waveform |
| wrap_o | output | 1 | One-clock strobe at each timer wrap |

## Verification
The main function is exercised with these settings:
- a mid-range compare value at a ratio of 1;
- a compare value of zero;
- a compare value equal to the period and one above it;
- a full 8-bit period at half duty;
- prescaled ratios of 4 and 256.

Together these cases separate three behaviours: the normal clear on match, the priority of the zero-compare clear over the set, and the suppressed clear when the compare is not below the period. They also catch a period counted as P instead of P+1, and a wrong entry in the ratio map.

Dedicated sequences cover three more behaviours:
- a period write in mid-period, to check that the holding register delays the change to the next wrap;
- a select change in mid-count, to check that the prescaler restarts instead of running on from its stale count;
- disabling the block, to check that the output goes low and the wraps stop.

// File: rtl/pwm_oc_pkg.sv
`timescale 1ns/1ps
package pwm_oc_pkg;
  localparam int PS_W = 8;  // widest prescale ratio is 2**8

  typedef enum logic [1:0] {
    ADDR_PER = 2'd0,
    ADDR_CMP = 2'd1,
    ADDR_CTL = 2'd2
  } reg_addr_e;

  // select code -> log2 of the clock-per-tick ratio
  function automatic logic [3:0] ps_shift(input logic [2:0] sel);
    return (sel == 3'd7) ? 4'd8 : {1'b0, sel};
  endfunction
endpackage

// File: rtl/pwm_oc_regs.sv
`timescale 1ns/1ps
module pwm_oc_regs
  import pwm_oc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             load_i,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             en_o,
  output logic [2:0]       sel_o,
  output logic             sel_chg_o
);
  logic [CNT_W-1:0] per_sh_q, cmp_sh_q, per_q, cmp_q;
  logic             en_q;
  logic [2:0]       sel_q;
  logic             wr_per, wr_cmp, wr_ctl;

  assign wr_per = wr_en_i && (wr_addr_i == ADDR_PER);
  assign wr_cmp = wr_en_i && (wr_addr_i == ADDR_CMP);
  assign wr_ctl = wr_en_i && (wr_addr_i == ADDR_CTL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_sh_q <= '0;
      cmp_sh_q <= '0;
      en_q     <= 1'b0;
      sel_q    <= '0;
    end else begin
      if (wr_per) per_sh_q <= wr_data_i;
      if (wr_cmp) cmp_sh_q <= wr_data_i;
      if (wr_ctl) begin
        en_q  <= wr_data_i[0];
        sel_q <= wr_data_i[3:1];
      end
    end
  end

  // working copies move only at rollover or while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= '0;
      cmp_q <= '0;
    end else if (load_i) begin
      per_q <= per_sh_q;
      cmp_q <= cmp_sh_q;
    end
  end

  assign per_o     = per_q;
  assign cmp_o     = cmp_q;
  assign en_o      = en_q;
  assign sel_o     = sel_q;
  assign sel_chg_o = wr_ctl && (wr_data_i[3:1] != sel_q);
endmodule

// File: rtl/pwm_oc_prescaler.sv
`timescale 1ns/1ps
module pwm_oc_prescaler
  import pwm_oc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [2:0] sel_i,
  input  logic       clr_i,
  output logic       tick_o
);
  logic [PS_W:0]   full;
  logic [PS_W-1:0] lim, cnt_q;

  assign full = {{PS_W{1'b0}}, 1'b1} << ps_shift(sel_i);
  assign lim  = PS_W'(full - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!en_i || clr_i)     cnt_q <= '0;
    else if (cnt_q == lim)       cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && !clr_i && (cnt_q == lim);
endmodule

// File: rtl/pwm_oc_timebase.sv
`timescale 1ns/1ps
module pwm_oc_timebase #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] tmr_o,
  output logic             roll_o,
  output logic             wrap_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] tmr_q;
  logic             wrap_q, pwm_q, pwm_d;

  assign roll_o = tick_i && (tmr_q == per_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tmr_q <= '0;
    else if (!en_i)   tmr_q <= '0;
    else if (roll_o)  tmr_q <= '0;
    else if (tick_i)  tmr_q <= tmr_q + 1'b1;
  end

  // zero compare wins over the set; compare at/above period never clears
  always_comb begin
    if (!en_i)                pwm_d = 1'b0;
    else if (cmp_i == '0)     pwm_d = 1'b0;
    else if (cmp_i >= per_i)  pwm_d = 1'b1;
    else                      pwm_d = (tmr_q < cmp_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wrap_q <= 1'b0;
      pwm_q  <= 1'b0;
    end else begin
      wrap_q <= en_i && roll_o;
      pwm_q  <= pwm_d;
    end
  end

  assign tmr_o  = tmr_q;
  assign wrap_o = wrap_q;
  assign pwm_o  = pwm_q;
endmodule

// File: rtl/pwm_oc_gen.sv
`timescale 1ns/1ps
module pwm_oc_gen #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             pwm_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] per_act, cmp_act, tmr_q;
  logic             en_q, sel_chg, tick, roll;
  logic [2:0]       sel_q;

  pwm_oc_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .load_i    (roll || !en_q),
    .per_o     (per_act),
    .cmp_o     (cmp_act),
    .en_o      (en_q),
    .sel_o     (sel_q),
    .sel_chg_o (sel_chg)
  );

  pwm_oc_prescaler u_ps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_q),
    .sel_i  (sel_q),
    .clr_i  (sel_chg),
    .tick_o (tick)
  );

  pwm_oc_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_q),
    .tick_i (tick),
    .per_i  (per_act),
    .cmp_i  (cmp_act),
    .tmr_o  (tmr_q),
    .roll_o (roll),
    .wrap_o (wrap_o),
    .pwm_o  (pwm_o)
  );
endmodule

// File: rtl/pwm_oc_chk.sv
`timescale 1ns/1ps
module pwm_oc_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en,
  input logic             tick,
  input logic [CNT_W-1:0] tmr,
  input logic [CNT_W-1:0] per,
  input logic [CNT_W-1:0] cmp,
  input logic             pwm_o,
  input logic             wrap_o
);
  AST_TMR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !tick) |=> $stable(tmr)); // R1
  AST_TMR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr <= per); // R2
  AST_WRAP_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> (tmr == '0)); // R2
  AST_WIDE_CMP_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && cmp != '0 && cmp >= per) |=> pwm_o); // R5
  AST_ZERO_CMP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp == '0) |=> !pwm_o); // R6
  AST_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> (!pwm_o && !wrap_o)); // R8
endmodule

bind pwm_oc_gen pwm_oc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en     (en_q),
  .tick   (tick),
  .tmr    (tmr_q),
  .per    (per_act),
  .cmp    (cmp_act),
  .pwm_o  (pwm_o),
  .wrap_o (wrap_o)
);

// File: tb/sim_pwm_oc_gen.sv
`timescale 1ns/1ps
module sim_pwm_oc_gen;
  localparam int CNT_W = 8;

  typedef struct {
    int    len;
    int    high;
    string req;
  } exp_t;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             wr_en_i = 1'b0;
  logic [1:0]       wr_addr_i = '0;
  logic [CNT_W-1:0] wr_data_i = '0;
  logic             pwm_o, wrap_o;

  int   n_chk = 0, n_err = 0;
  exp_t sb_q[$];
  bit   mon_on = 1'b0;
  int   skip = 0;
  int   m_len = 0, m_high = 0;
  bit   done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pwm_oc_gen #(.CNT_W(CNT_W)) u0 (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .pwm_o, .wrap_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = CNT_W'(d);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // driver: program from idle, queue expected periods
  task automatic run_case(input int per, input int cmp, input int sel,
                          input int len, input int high, input string req);
    mon_on = 1'b0;
    wr(2'd2, 0);
    wr(2'd0, per);
    wr(2'd1, cmp);
    skip = 1;
    for (int i = 0; i < 3; i++) sb_q.push_back('{len, high, req});
    mon_on = 1'b1;
    wr(2'd2, (sel << 1) | 1);
    wait (sb_q.size() == 0);
    mon_on = 1'b0;
  endtask

  // monitor: measure each period between wrap strobes
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (wrap_o) begin
        if (mon_on) begin
          if (skip > 0) skip--;
          else if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk(m_len == e.len,  {e.req, " period"}, m_len,  e.len);
            chk(m_high == e.high, {e.req, " high"},  m_high, e.high);
          end
        end
        m_len = 1; m_high = int'(pwm_o);
      end else begin
        m_len++; m_high += int'(pwm_o);
      end
    end
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end

  initial begin
    int n;
    #12 rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 reset state
    chk(pwm_o == 1'b0, "R10 pwm", int'(pwm_o), 0);
    chk(wrap_o == 1'b0, "R10 wrap", int'(wrap_o), 0);

    run_case(9, 3, 0, 10, 3, "R3 mid duty");
    run_case(9, 0, 0, 10, 0, "R6 zero cmp");
    run_case(9, 9, 0, 10, 10, "R5 cmp eq per");
    run_case(9, 12, 0, 10, 10, "R5 cmp above per");
    run_case(255, 128, 0, 256, 128, "R4 8-bit half");
    run_case(255, 1, 0, 256, 1, "R4 one step");
    run_case(4, 2, 2, 20, 8, "R1 ratio 4");
    run_case(1, 1, 7, 512, 512, "R1 ratio 256");
    run_case(3, 2, 1, 8, 4, "R2 ratio 2");

    // R7: mid-period period write waits for rollover
    wr(2'd2, 0); wr(2'd0, 9); wr(2'd1, 3); wr(2'd2, 1);
    while (!wrap_o) @(negedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 2'd0; wr_data_i = 8'd5;
    n = 1;
    @(negedge clk_i);
    wr_en_i = 1'b0; n = 2;
    while (!wrap_o) begin @(negedge clk_i); n++; end
    chk(n == 10, "R7 old period kept", n, 10);
    n = 0;
    do begin @(negedge clk_i); n++; end while (!wrap_o);
    chk(n == 6, "R7 new period used", n, 6);

    // R9: select change restarts prescaler
    wr(2'd2, 0); wr(2'd0, 0); wr(2'd1, 0); wr(2'd2, (4 << 1) | 1);
    while (!wrap_o) @(negedge clk_i);
    repeat (5) @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 2'd2; wr_data_i = 8'((2 << 1) | 1);
    n = 0;
    @(negedge clk_i);
    wr_en_i = 1'b0; n = 1;
    while (!wrap_o && n < 400) begin @(negedge clk_i); n++; end
    chk(n == 5, "R9 restart delay", n, 5);

    // R8: disable forces low and stops wraps
    wr(2'd2, 0); wr(2'd0, 9); wr(2'd1, 12); wr(2'd2, 1);
    repeat (25) @(negedge clk_i);
    chk(pwm_o == 1'b1, "R8 running high", int'(pwm_o), 1);
    wr(2'd2, 0);
    @(negedge clk_i);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (pwm_o || wrap_o) n++;
    end
    chk(n == 0, "R8 idle low no wrap", n, 0);

    done = 1'b1;
    summary();
  end
endmodule